// File: doc/BRIEF.md
# Fractional-Increment Realtime Counter

This block keeps a free-running 64-bit time count that advances at a fixed nominal rate, whatever the frequency of the clock that drives it. On every input clock it adds a programmable numerator to a small fractional accumulator. When the accumulator reaches the programmable denominator, the count steps by one and the accumulator wraps. Averaged over time, the count therefore rises at the input rate times numerator divided by denominator.

The intended target is 6.144 MHz. Typical ratios for that target are:

- 8/25 for a 19.2 MHz clock
- 4/25 for 38.4 MHz
- 64/125 for 12 MHz
- 768/1625 for 13 MHz
- 192/625 for 20 MHz
- 384/1625 for 26 MHz
- 256/1125 for 27 MHz
- 75/244 when the slow reference is only emulated from the input clock

Software sets the ratio through two 32-bit registers on a simple write/read bus. The count and a one-cycle tick pulse leave the block as plain outputs. Software has no way to stop, load or clear the count.

Top module: `frac_rate_counter`

## Requirements
- R1: After reset the count is 0 and the tick is low. The numerator register reads 0x00000008 and the denominator register reads 0x00000019.
- R2: The numerator register is at offset 0x10 and the denominator register at offset 0x14. The ratio value sits in bits 11:0 of each register. Bits 31:12 are stored as written and read back unchanged. A read of any other offset returns 0, and a write to any other offset changes neither register nor the count.
- R3: With a nonzero denominator and a numerator below it, each input clock adds the numerator to the accumulator. When the sum is at or above the denominator, the denominator is subtracted and the count rises by one in that same clock. As a result, N clocks after a ratio write the count has risen by exactly floor(N*num/den).
- R4: The tick output is high for exactly one cycle for each increment of the count, in the cycle in which the new count value is first visible. The count never changes while the tick is low.
- R5: A write to either ratio register clears the accumulator in that clock, and the count does not advance in that clock. The new ratio therefore starts from phase zero.
- R6: While the denominator field is 0, the count holds its value, the tick stays low and the error output is high. The error output returns low once a nonzero denominator is written.
- R7: When the numerator is equal to or greater than a nonzero denominator, the count rises by one on every input clock and the accumulator stays at zero.
- R8: A numerator of zero with a nonzero denominator holds the count still, with the error output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Variable-frequency input clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read enable (read data is combinational) |
| busAddr | input | 8 | Byte offset of the register |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, 0 when not reading or when the offset is unmapped |
| count | output | 64 | Free-running time count |
| tick | output | 1 | One-cycle pulse on each count increment |
| ratioErr | output | 1 | High while the denominator field is zero |

## Verification
The assertions check four properties on every cycle. Each tick pairs with a single-step increment and no increment happens without a tick. The accumulator stays below a nonzero denominator. A ratio write clears the phase without advancing the count. A zero denominator or an oversized numerator gives the hold or every-clock behaviour.

Only the bench scenarios can show the long-run average. The bench sweeps every small ratio and every target ratio, and each time compares the count gained over a window with floor(N*num/den) computed in the bench. Separate scenarios cover phase restart on a rewrite, storage of the upper register bits, and unmapped offsets.

// File: rtl/frc_pkg.sv
package frc_pkg;
  // Strobes from register control to the accumulator datapath
  typedef struct packed {
    logic accClr;  // a ratio register was written this cycle
    logic run;     // denominator is nonzero, counting allowed
  } frcStrobe_t;
endpackage

// File: rtl/frc_ctrl.sv
module frc_ctrl
  import frc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int FRAC_W = 12,
  parameter logic [ADDR_W-1:0] NUM_OFFS = 8'h10,
  parameter logic [ADDR_W-1:0] DEN_OFFS = 8'h14,
  parameter logic [DATA_W-1:0] NUM_RST = 32'h0000_0008,
  parameter logic [DATA_W-1:0] DEN_RST = 32'h0000_0019
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic [FRAC_W-1:0] numField,
  output logic [FRAC_W-1:0] denField,
  output logic              ratioErr,
  output frcStrobe_t        strobes
);
  localparam int N_REGS = 2;
  localparam logic [ADDR_W-1:0] REG_OFFS [N_REGS] = '{NUM_OFFS, DEN_OFFS};
  localparam logic [DATA_W-1:0] REG_RST  [N_REGS] = '{NUM_RST, DEN_RST};

  logic [DATA_W-1:0] ratioReg [N_REGS];
  logic [N_REGS-1:0] wrHit;
  logic [N_REGS-1:0] rdHit;

  for (genvar i = 0; i < N_REGS; i++) begin : g_reg
    assign wrHit[i] = busWrEn && (busAddr == REG_OFFS[i]);
    assign rdHit[i] = busRdEn && (busAddr == REG_OFFS[i]);
    always_ff @(posedge clk) begin
      if (!rstN) ratioReg[i] <= REG_RST[i];
      else if (wrHit[i]) ratioReg[i] <= busWrData;
    end
  end

  always_comb begin
    busRdData = '0;
    for (int i = 0; i < N_REGS; i++)
      if (rdHit[i]) busRdData = ratioReg[i];
  end

  assign numField       = ratioReg[0][FRAC_W-1:0];
  assign denField       = ratioReg[1][FRAC_W-1:0];
  assign ratioErr       = (denField == '0);
  assign strobes.accClr = |wrHit;
  assign strobes.run    = !ratioErr;

  // R2: writes elsewhere leave both registers untouched
  assert_unmapped_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr != NUM_OFFS && busAddr != DEN_OFFS)
      |=> ($stable(ratioReg[0]) && $stable(ratioReg[1])));
endmodule

// File: rtl/frc_datapath.sv
module frc_datapath
  import frc_pkg::*;
#(
  parameter int FRAC_W = 12,
  parameter int CNT_W  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  frcStrobe_t        strobes,
  input  logic [FRAC_W-1:0] numField,
  input  logic [FRAC_W-1:0] denField,
  output logic [CNT_W-1:0]  count,
  output logic              tick
);
  localparam int SUM_W = FRAC_W + 1;

  logic [FRAC_W-1:0] acc;
  logic [SUM_W-1:0]  sum;
  logic [SUM_W-1:0]  sumWrapped;
  logic              fastRatio;
  logic              carry;

  assign sum        = {1'b0, acc} + {1'b0, numField};
  assign sumWrapped = sum - {1'b0, denField};
  assign fastRatio  = (numField >= denField);
  assign carry      = (sum >= {1'b0, denField});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc   <= '0;
      count <= '0;
      tick  <= 1'b0;
    end else if (strobes.accClr) begin
      acc  <= '0;
      tick <= 1'b0;
    end else if (!strobes.run) begin
      tick <= 1'b0;
    end else if (fastRatio) begin
      acc   <= '0;
      count <= count + 1'b1;
      tick  <= 1'b1;
    end else if (carry) begin
      acc   <= sumWrapped[FRAC_W-1:0];
      count <= count + 1'b1;
      tick  <= 1'b1;
    end else begin
      acc  <= sum[FRAC_W-1:0];
      tick <= 1'b0;
    end
  end

  // R4: a tick always accompanies a single-step increment
  assert_tick_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    tick |-> (count == $past(count) + 1'b1));
  // R4: no increment without a tick
  assert_quiet_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !tick |-> $stable(count));
  // R3: accumulator phase stays below a nonzero denominator
  assert_acc_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    (denField != '0) |-> (acc < denField));
  // R5: ratio write restarts the phase without advancing
  assert_clear_on_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.accClr |=> (acc == '0 && !tick));
  // R6: zero denominator freezes the count
  assert_zero_den_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.run && !strobes.accClr) |=> !tick);
  // R7: oversized numerator advances on every clock
  assert_fast_ratio_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.run && !strobes.accClr && fastRatio) |=> (tick && acc == '0));
endmodule

// File: rtl/frac_rate_counter.sv
module frac_rate_counter
  import frc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int FRAC_W = 12,
  parameter int CNT_W  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic [CNT_W-1:0]  count,
  output logic              tick,
  output logic              ratioErr
);
  frcStrobe_t        strobes;
  logic [FRAC_W-1:0] numField;
  logic [FRAC_W-1:0] denField;

  frc_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FRAC_W(FRAC_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .numField(numField), .denField(denField), .ratioErr(ratioErr),
    .strobes(strobes)
  );

  frc_datapath #(
    .FRAC_W(FRAC_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .numField(numField), .denField(denField),
    .count(count), .tick(tick)
  );
endmodule

// File: tb/frac_rate_counter_bench.sv
`timescale 1ns/1ps
module frac_rate_counter_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [63:0] count;
  logic        tick;
  logic        ratioErr;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  frac_rate_counter u_frac_rate_counter (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .count(count), .tick(tick), .ratioErr(ratioErr)
  );

  task automatic check(string req, longint unsigned actual, longint unsigned expected);
    vectors++;
    if (actual != expected) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic busWrite(logic [7:0] addr, logic [31:0] data);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = addr; busWrData = data;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(logic [7:0] addr, output logic [31:0] data);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = addr;
    #1 data = busRdData;
    busRdEn = 1'b0;
  endtask

  // runs n clocks, returns count gain and number of tick pulses seen
  task automatic runFor(int n, output longint unsigned gain, output longint unsigned ticks);
    longint unsigned base = count;
    ticks = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (tick) ticks++;
    end
    gain = count - base;
  endtask

  task automatic ratioRun(int num, int den, int n);
    longint unsigned gain, ticks, expGain;
    busWrite(8'h10, 32'(num));
    busWrite(8'h14, 32'(den));
    runFor(n, gain, ticks);
    if (den == 0) expGain = 0;
    else if (num >= den) expGain = longint'(n);
    else expGain = (longint'(n) * num) / den;
    if (den == 0) check("R6", gain, 0);
    else if (num == 0) check("R8", gain, 0);
    else if (num >= den) check("R7", gain, expGain);
    else check("R3", gain, expGain);
    check("R4", ticks, expGain);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    longint unsigned gain, ticks;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", count, 0);
    check("R1", tick, 0);
    busRead(8'h10, rd); check("R1", rd, 32'h8);
    busRead(8'h14, rd); check("R1", rd, 32'h19);

    // R2: upper bits stored, unmapped offsets inert
    busWrite(8'h10, 32'hABCDE004);
    busWrite(8'h14, 32'h12345019);
    busRead(8'h10, rd); check("R2", rd, 32'hABCDE004);
    busRead(8'h14, rd); check("R2", rd, 32'h12345019);
    busRead(8'h20, rd); check("R2", rd, 0);
    busWrite(8'h20, 32'h0000_0001);
    busRead(8'h10, rd); check("R2", rd, 32'hABCDE004);
    busRead(8'h14, rd); check("R2", rd, 32'h12345019);
    busWrite(8'h14, 32'h12345019);
    runFor(250, gain, ticks); check("R2", gain, 40);  // ratio 4/25 from low bits

    // near-exhaustive sweep of small ratios (R3, R7, R8)
    for (int d = 1; d <= 7; d++)
      for (int nm = 0; nm <= 8; nm++)
        ratioRun(nm, d, 53);

    // target ratios, long windows (R3)
    ratioRun(8, 25, 2000);
    ratioRun(4, 25, 2000);
    ratioRun(64, 125, 2000);
    ratioRun(768, 1625, 3000);
    ratioRun(192, 625, 2000);
    ratioRun(384, 1625, 3000);
    ratioRun(256, 1125, 3000);
    ratioRun(75, 244, 2000);
    ratioRun(4095, 4095, 100);

    // R6: zero denominator
    ratioRun(5, 0, 40);
    @(negedge clk); check("R6", ratioErr, 1);
    busWrite(8'h14, 32'd7);
    check("R6", ratioErr, 0);
    busWrite(8'h10, 32'd0);
    check("R8", ratioErr, 0);

    // R5: rewrite restarts phase. 1/4: 3 clocks -> acc 3; rewrite; 3 more clocks no step
    busWrite(8'h10, 32'd1);
    busWrite(8'h14, 32'd4);
    runFor(3, gain, ticks); check("R5", gain, 0);
    busWrite(8'h10, 32'd1);      // write clock itself must not advance
    check("R5", tick, 0);
    runFor(2, gain, ticks); check("R5", gain, 0);
    runFor(1, gain, ticks); check("R5", gain, 0);
    runFor(1, gain, ticks); check("R5", gain, 1);
    check("R4", tick, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule